// File: doc/BRIEF.md
# DRAM Auto-Refresh Command Sequencer

This block lives inside a mobile DDR SDRAM controller and owns the refresh traffic. A free-running interval timer adds one refresh to a tally of owed refreshes each time it wraps. The tally saturates at a configurable limit. While any refresh is owed and the sequencer is idle, it asks the command arbiter for the bus.

Once the arbiter grants the bus, the sequencer closes whatever banks are open. It uses one all-bank precharge when several banks are open and a single-bank precharge when only one is open. It skips this step when every bank is already closed. After the precharge recovery time it issues AUTO REFRESH commands back to back, one per owed refresh, spaced by the refresh cycle time, with only NOP on the bus in between. It then pulses a done signal and returns the bus to the arbiter. Clock enable stays high throughout, and the block never touches the data path.

All timings are parameters counted in clock cycles: recovery after precharge, refresh cycle time, refresh interval, and the maximum number of owed refreshes.

Top module: `dram_refresh_seq`

## Requirements
- R1: `req_o` first rises exactly `T_REFI` clock edges after reset release. It stays high while at least one refresh is owed and the sequencer is idle, and it is low while a sequence is running.
- R2: The owed tally grows by one per interval and never exceeds `MAX_OWED`. One granted sequence issues exactly as many AUTO REFRESH commands (cs_n,ras_n,cas_n,we_n = 0,0,0,1) as are owed when it starts, provided no interval ends during the burst.
- R3: `grant_i` has no effect while `req_o` is low. The bus stays deselected (`cs_n_o` = 1) and no command is issued.
- R4: When two or more banks are open at grant, the first command is one PRECHARGE (0,0,1,0) with `a10_o` = 1 and `ba_o` = 0.
- R5: When exactly one bank is open at grant, the PRECHARGE has `a10_o` = 0 and `ba_o` equal to that bank's index (bit n of `bank_open_i` is bank n).
- R6: When no bank is open at grant, no PRECHARGE is issued and the first command is AUTO REFRESH.
- R7: The first AUTO REFRESH follows the PRECHARGE by exactly `T_RP` cycles.
- R8: Consecutive AUTO REFRESH commands are exactly `T_RFC` cycles apart. Every cycle between commands of a sequence carries NOP (0,1,1,1).
- R9: `done_o` is a single-cycle pulse exactly `T_RFC` cycles after the last AUTO REFRESH. In that cycle the bus is deselected, and afterwards `req_o` stays low until the next interval ends.
- R10: `cke_o` is high at every clock edge, in reset and out of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_open_i | input | NUM_BANKS | One bit per bank, high when that bank has an open row |
| grant_i | input | 1 | Arbiter hands the command bus to the sequencer |
| req_o | output | 1 | Refresh owed and sequencer idle |
| done_o | output | 1 | One-cycle pulse when the bus is released |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | All-bank flag on PRECHARGE |
| ba_o | output | BA_W | Bank address for a single-bank PRECHARGE |
| cke_o | output | 1 | Clock enable, held high |

## Verification
The bench drives open-bank patterns with none, one and several banks open, so it can catch a design that precharges a closed device or sends a single-bank precharge to the wrong bank instead of closing all of them. It lets refreshes pile up beyond the tally limit; a tally that wraps instead of saturating yields too few or too many refresh commands. It measures every command spacing exactly, so a recovery counter that is off by one places a refresh a cycle early or late and a misplaced done pulse shows. It also asserts a grant with no request pending, which a sequencer with a loose start condition would turn into a stray refresh.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PRE  = 3'd1,
    S_WRP  = 3'd2,
    S_AREF = 3'd3,
    S_WRFC = 3'd4,
    S_DONE = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam ddr_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int T_REFI   = 1560,
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  output logic              owed_nz_o,
  output logic [OWED_W-1:0] owed_o
);

  localparam int REFI_W = (T_REFI > 1) ? $clog2(T_REFI) : 1;

  logic [REFI_W-1:0] tmr_q, tmr_d;
  logic [OWED_W-1:0] owed_q, owed_d;
  logic              wrap;

  assign wrap = (tmr_q == REFI_W'(T_REFI - 1));

  always_comb begin
    tmr_d = wrap ? '0 : tmr_q + 1'b1;
  end

  always_comb begin
    owed_d = owed_q;
    if (wrap && !issue_i) begin
      if (owed_q != OWED_W'(MAX_OWED)) owed_d = owed_q + 1'b1;
    end else if (!wrap && issue_i) begin
      if (owed_q != '0) owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      owed_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      owed_q <= owed_d;
    end
  end

  assign owed_nz_o = (owed_q != '0);
  assign owed_o    = owed_q;

endmodule

// File: rtl/rfsh_wait_ctr.sv
module rfsh_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)             cnt_d = val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
  import rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 22,
  parameter int CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 grant_i,
  input  logic                 owed_nz_i,
  input  logic [CNT_W-1:0]     wait_cnt_i,
  output logic                 wait_load_o,
  output logic [CNT_W-1:0]     wait_val_o,
  output logic                 issue_o,
  output logic                 req_o,
  output logic                 done_o,
  output ddr_cmd_t             cmd_o,
  output logic                 a10_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [NUM_BANKS-1:0] snap_o
);

  seq_state_t           state_q, state_d;
  logic [NUM_BANKS-1:0] snap_q;
  logic                 start;
  logic                 expired;
  logic                 multi_open;
  logic [BA_W-1:0]      first_idx;

  assign start   = (state_q == S_IDLE) && owed_nz_i && grant_i;
  assign expired = (wait_cnt_i <= CNT_W'(1));

  always_comb begin
    first_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (snap_q[i]) first_idx = BA_W'(i);
    end
  end

  assign multi_open = ($countones(snap_q) > 1);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start) state_d = (|bank_open_i) ? S_PRE : S_AREF;
      S_PRE:  state_d = S_WRP;
      S_WRP:  if (expired) state_d = S_AREF;
      S_AREF: state_d = S_WRFC;
      S_WRFC: if (expired) state_d = owed_nz_i ? S_AREF : S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (start) snap_q <= bank_open_i;
  end

  always_comb begin
    wait_load_o = 1'b0;
    wait_val_o  = '0;
    if (state_q == S_PRE) begin
      wait_load_o = 1'b1;
      wait_val_o  = CNT_W'(T_RP - 1);
    end else if (state_q == S_AREF) begin
      wait_load_o = 1'b1;
      wait_val_o  = CNT_W'(T_RFC - 1);
    end
  end

  always_comb begin
    cmd_o = CMD_DESEL;
    a10_o = 1'b0;
    ba_o  = '0;
    case (state_q)
      S_PRE: begin
        cmd_o = CMD_PRE;
        a10_o = multi_open;
        ba_o  = multi_open ? '0 : first_idx;
      end
      S_WRP, S_WRFC: cmd_o = CMD_NOP;
      S_AREF:        cmd_o = CMD_AREF;
      default:       cmd_o = CMD_DESEL;
    endcase
  end

  assign issue_o = (state_q == S_AREF);
  assign req_o   = (state_q == S_IDLE) && owed_nz_i;
  assign done_o  = (state_q == S_DONE);
  assign snap_o  = snap_q;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 22,
  parameter int T_REFI    = 1560,
  parameter int MAX_OWED  = 8,
  parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 grant_i,
  output logic                 req_o,
  output logic                 done_o,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 a10_o,
  output logic [BA_W-1:0]      ba_o,
  output logic                 cke_o
);

  localparam int WAIT_MAX = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam int OWED_W   = $clog2(MAX_OWED + 1);

  logic                 owed_nz;
  logic [OWED_W-1:0]    owed_cnt;
  logic                 issue;
  logic                 wait_load;
  logic [CNT_W-1:0]     wait_val;
  logic [CNT_W-1:0]     wait_cnt;
  logic [NUM_BANKS-1:0] bank_snap;
  ddr_cmd_t             cmd;

  rfsh_interval #(
    .T_REFI  (T_REFI),
    .MAX_OWED(MAX_OWED),
    .OWED_W  (OWED_W)
  ) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue),
    .owed_nz_o(owed_nz),
    .owed_o   (owed_cnt)
  );

  rfsh_wait_ctr #(
    .W(CNT_W)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(wait_load),
    .val_i (wait_val),
    .cnt_o (wait_cnt)
  );

  rfsh_fsm #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_open_i(bank_open_i),
    .grant_i    (grant_i),
    .owed_nz_i  (owed_nz),
    .wait_cnt_i (wait_cnt),
    .wait_load_o(wait_load),
    .wait_val_o (wait_val),
    .issue_o    (issue),
    .req_o      (req_o),
    .done_o     (done_o),
    .cmd_o      (cmd),
    .a10_o      (a10_o),
    .ba_o       (ba_o),
    .snap_o     (bank_snap)
  );

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign cke_o   = 1'b1;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 22,
  parameter int MAX_OWED  = 8,
  parameter int OWED_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_o,
  input logic                 done_o,
  input logic                 cs_n_o,
  input logic                 ras_n_o,
  input logic                 cas_n_o,
  input logic                 we_n_o,
  input logic                 a10_o,
  input logic [BA_W-1:0]      ba_o,
  input logic [NUM_BANKS-1:0] bank_snap,
  input logic [OWED_W-1:0]    owed_cnt
);

  logic [3:0] bus;
  logic       is_pre, is_ar, is_nop;
  logic [15:0] since_pre, since_ar;
  logic        pre_armed, ar_armed;

  assign bus    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_pre = (bus == 4'b0010);
  assign is_ar  = (bus == 4'b0001);
  assign is_nop = (bus == 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= '1;
      since_ar  <= '1;
      pre_armed <= 1'b0;
      ar_armed  <= 1'b0;
    end else begin
      if (is_pre)                 since_pre <= 16'd1;
      else if (since_pre != '1)   since_pre <= since_pre + 16'd1;
      if (is_ar)                  since_ar  <= 16'd1;
      else if (since_ar != '1)    since_ar  <= since_ar + 16'd1;
      if (is_pre)     pre_armed <= 1'b1;
      else if (is_ar) pre_armed <= 1'b0;
      if (is_ar)      ar_armed  <= 1'b1;
    end
  end

  p_owed_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= OWED_W'(MAX_OWED));

  p_grant_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && !req_o && !done_o) |=> cs_n_o);

  p_all_bank_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && ($countones(bank_snap) > 1)) |-> (a10_o && ba_o == '0));

  p_one_bank_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && ($countones(bank_snap) == 1)) |-> (!a10_o && bank_snap[ba_o]));

  p_rp_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ar && pre_armed) |-> (since_pre == 16'(T_RP)));

  p_rfc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_armed && since_ar < 16'(T_RFC)) |-> is_nop);

  p_done_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ar_armed && since_ar == 16'(T_RFC) && cs_n_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind dram_refresh_seq rfsh_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BA_W     (BA_W),
  .T_RP     (T_RP),
  .T_RFC    (T_RFC),
  .MAX_OWED (MAX_OWED),
  .OWED_W   (OWED_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_o    (req_o),
  .done_o   (done_o),
  .cs_n_o   (cs_n_o),
  .ras_n_o  (ras_n_o),
  .cas_n_o  (cas_n_o),
  .we_n_o   (we_n_o),
  .a10_o    (a10_o),
  .ba_o     (ba_o),
  .bank_snap(bank_snap),
  .owed_cnt (owed_cnt)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int TRP   = 3;
  localparam int TRFC  = 6;
  localparam int TREFI = 40;
  localparam int MAXO  = 3;

  // banks[13:10] nwait[9:7] pre[6] a10[5] ba[4:3] nar[2:0]
  localparam logic [13:0] VEC [6] = '{
    {4'b0000, 3'd1, 1'b0, 1'b0, 2'd0, 3'd1},
    {4'b0100, 3'd1, 1'b1, 1'b0, 2'd2, 3'd1},
    {4'b1011, 3'd2, 1'b1, 1'b1, 2'd0, 3'd2},
    {4'b1111, 3'd3, 1'b1, 1'b1, 2'd0, 3'd3},
    {4'b0001, 3'd5, 1'b1, 1'b0, 2'd0, 3'd3},
    {4'b0000, 3'd2, 1'b0, 1'b0, 2'd0, 3'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] bank_open;
  logic          grant;
  logic          req, done, cs_n, ras_n, cas_n, we_n, a10, cke;
  logic [1:0]    ba;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(
    .NUM_BANKS(NB), .T_RP(TRP), .T_RFC(TRFC), .T_REFI(TREFI), .MAX_OWED(MAXO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open), .grant_i(grant),
    .req_o(req), .done_o(done), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10), .ba_o(ba), .cke_o(cke)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      summary();
    end
  end

  task automatic run_case(input logic [13:0] v, input int idx);
    logic [3:0] bus;
    int pre_t, n_ar, done_t, last_ar, first_ar;
    int gap_bad, bus_bad, cke_bad, req_bad;
    logic pre_a10;
    logic [1:0] pre_ba;
    pre_t = -1; n_ar = 0; done_t = -1; last_ar = -1; first_ar = -1;
    gap_bad = 0; bus_bad = 0; cke_bad = 0; req_bad = 0;
    pre_a10 = 1'b0; pre_ba = '0;
    while (!req) @(negedge clk);
    repeat ((int'(v[9:7]) - 1) * TREFI + 2) @(negedge clk);
    bank_open = v[13:10];
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    for (int t = 0; t < 100; t++) begin
      bus = {cs_n, ras_n, cas_n, we_n};
      if (!cke) cke_bad++;
      if (req) req_bad++;
      if (done) begin
        done_t = t;
        break;
      end
      if (bus == 4'b0010 && pre_t < 0 && n_ar == 0) begin
        pre_t = t; pre_a10 = a10; pre_ba = ba;
      end else if (bus == 4'b0001) begin
        if (n_ar == 0) first_ar = t;
        else if (t - last_ar != TRFC) gap_bad++;
        last_ar = t;
        n_ar++;
      end else if (bus != 4'b0111) begin
        bus_bad++;
      end
      @(negedge clk);
    end
    $display("case %0d: banks=%b pre_t=%0d ars=%0d done_t=%0d", idx, v[13:10], pre_t, n_ar, done_t);
    if (v[6]) begin
      chk(pre_t == 0, "R4/R5 precharge first", pre_t, 0);
      if (v[5]) begin
        chk(pre_a10 == 1'b1, "R4 a10", pre_a10, 1);
        chk(pre_ba == 2'd0, "R4 ba", pre_ba, 0);
      end else begin
        chk(pre_a10 == 1'b0, "R5 a10", pre_a10, 0);
        chk(pre_ba == v[4:3], "R5 ba", pre_ba, v[4:3]);
      end
      chk(first_ar - pre_t == TRP, "R7 pre to refresh", first_ar - pre_t, TRP);
    end else begin
      chk(pre_t == -1, "R6 no precharge", pre_t, -1);
      chk(first_ar == 0, "R6 refresh first", first_ar, 0);
    end
    chk(n_ar == int'(v[2:0]), "R2 refresh count", n_ar, v[2:0]);
    chk(gap_bad == 0, "R8 refresh spacing", gap_bad, 0);
    chk(bus_bad == 0, "R8 nop between", bus_bad, 0);
    chk(done_t >= 0 && done_t - last_ar == TRFC, "R9 done position", done_t - last_ar, TRFC);
    chk(cs_n == 1'b1, "R9 bus released", cs_n, 1);
    chk(req_bad == 0, "R1 req low while busy", req_bad, 0);
    chk(cke_bad == 0 && cke, "R10 cke high", cke_bad, 0);
    @(negedge clk);
    chk(!done, "R9 done single pulse", done, 0);
    chk(!req, "R9 no request after burst", req, 0);
    bank_open = '0;
  endtask

  initial begin
    int rise_at;
    rst_n = 1'b0;
    grant = 1'b0;
    bank_open = '0;
    repeat (3) @(negedge clk);
    chk(!req, "R1 reset req", req, 0);
    chk(!done, "R9 reset done", done, 0);
    chk(cs_n, "R3 reset deselect", cs_n, 1);
    chk(cke, "R10 reset cke", cke, 1);
    rst_n = 1'b1;
    rise_at = -1;
    for (int k = 1; k <= TREFI + 5; k++) begin
      @(negedge clk);
      if (k >= 3 && k <= 8) begin
        chk(cs_n == 1'b1, "R3 grant without request", cs_n, 1);
        grant = (k < 8);
        bank_open = 4'b1111;
      end
      if (req && rise_at < 0) rise_at = k;
    end
    grant = 1'b0;
    bank_open = '0;
    chk(rise_at == TREFI, "R1 first request", rise_at, TREFI);
    for (int i = 0; i < 6; i++) run_case(VEC[i], i);
    summary();
  end

endmodule